// File: doc/BRIEF.md
# Mode-Steered Five-Pin GPIO Port

This block is a five-pin general-purpose I/O port. Each pin has a direction bit and a data bit. Both are loaded through a small write interface: one strobe loads every direction bit, another loads every data bit, and both take the same write-data word. When a pin is an output, it drives its data bit onto the pad. When it is an input, its output driver is switched off.

Pins 2, 3 and 4 can also carry the active-low chip-select strobes of an external bus controller. Two things together decide whether a pin does this: the chip's operating-mode input and that pin's direction bit. Pins 0 and 1 have no alternate use.

A read-back bus reports the pin states. For ordinary output pins it returns the data bit. For input pins and for pins that carry a chip-select, it returns the pad level after a two-flop synchronizer.

The block separates two groups of reset and standby requests:
- A power-on reset or a hardware standby request wipes the port registers.
- A manual reset or a software standby request keeps them.

Top module: `gport_mux`

## Requirements
- R1: While the active-low power-on reset `rst_n` is low, every output enable and every pad output is 0 and the direction and data registers are cleared. After release with no writes, the read-back follows the synchronized pad levels.
- R2: A high `hw_stby_i` sampled on a clock edge clears the direction and data registers at that edge. From then on every output enable is 0, and a clear takes priority over a write in the same cycle.
- R3: While `man_rst_i` or `sw_stby_i` is high (and `hw_stby_i` is low), the direction and data registers hold their values and write strobes are ignored.
- R4: Pin 4 with its direction bit set drives `cs_n_i[0]` when `mode_i` is 1, 2, 4, 5 or 6. It drives its data bit when `mode_i` is 3 or 7.
- R5: Pin 3 with its direction bit set drives `cs_n_i[1]` when `mode_i` is 4, 5 or 6. It drives its data bit in every other mode.
- R6: Pin 2 with its direction bit set drives `cs_n_i[2]` when `mode_i` is 4, 5 or 6. It drives its data bit in every other mode.
- R7: Mode value 0, and any value above 7 when `mode_i` is wider than 3 bits, makes every pin general-purpose, with no chip-select routing.
- R8: A pin whose direction bit is 0 has `pad_oe_o` 0 and `pad_out_o` 0 in every mode.
- R9: A routed chip-select reaches the pad combinationally, in the same cycle and without inversion, so an active-low strobe stays low on the pad.
- R10: Read-back bit i equals data bit i when pin i is a general-purpose output. It equals the synchronized pad level when the pin is an input or carries a chip-select.
- R11: A pad level change that is stable before a clock edge shows on the read-back for an input pin after exactly two rising edges.
- R12: Pins 0 and 1 never carry a chip-select. They drive their data bit whenever their direction bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous; clears the registers |
| hw_stby_i | input | 1 | Hardware standby request; clears the registers |
| man_rst_i | input | 1 | Manual reset; the registers are retained |
| sw_stby_i | input | 1 | Software standby request; the registers are retained |
| mode_i | input | MODE_W | Operating mode |
| wr_dir_i | input | 1 | Load the direction bits from `wdata_i` |
| wr_dat_i | input | 1 | Load the data bits from `wdata_i` |
| wdata_i | input | N_PIN | Write data, one bit per pin |
| cs_n_i | input | 3 | Active-low chip-selects 0..2 from the bus controller |
| pad_in_i | input | N_PIN | Pad input levels |
| pad_out_o | output | N_PIN | Pad output values |
| pad_oe_o | output | N_PIN | Pad output enables |
| rd_pins_o | output | N_PIN | Read-back of the pin states |

## Verification
The assertions are checked on every cycle, except while the power-on reset is low. They cover:
- the clearing done by hardware standby and the retention during manual reset and software standby;
- the absence of any chip-select routing in mode 0 or on pins 0 and 1;
- routed pads following the bus controller strobe;
- drivers being off on pins whose direction bit is clear;
- read-back of general-purpose outputs;
- the two-edge synchronizer delay.

Only the bench's scenarios show the full mode-by-pin routing table against expected pad values. They also show that the chip-select passes through within a cycle, and that reset and standby requests keep or wipe a configuration as seen at the ports.

// File: rtl/gport_pkg.sv
package gport_pkg;

  localparam int unsigned GP_NCS = 3;

  typedef struct packed {
    logic       act;
    logic [1:0] idx;
  } gp_route_t;

  // Chip-select routing for one pin in one mode (before the direction bit).
  function automatic gp_route_t gp_route(input int unsigned pin, input int unsigned mode);
    gp_route_t r;
    r = '0;
    case (pin)
      4: if (mode == 1 || mode == 2 || mode == 4 || mode == 5 || mode == 6) begin
           r.act = 1'b1;
           r.idx = 2'd0;
         end
      3: if (mode >= 4 && mode <= 6) begin
           r.act = 1'b1;
           r.idx = 2'd1;
         end
      2: if (mode >= 4 && mode <= 6) begin
           r.act = 1'b1;
           r.idx = 2'd2;
         end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gport_regs.sv
module gport_regs #(
  parameter int unsigned N_PIN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby_i,
  input  logic             man_rst_i,
  input  logic             sw_stby_i,
  input  logic             wr_dir_i,
  input  logic             wr_dat_i,
  input  logic [N_PIN-1:0] wdata_i,
  output logic [N_PIN-1:0] dir_o,
  output logic [N_PIN-1:0] dat_o
);

  logic wipe;
  logic hold;
  logic dir_we;
  logic dat_we;

  assign wipe   = hw_stby_i;
  assign hold   = man_rst_i | sw_stby_i;
  assign dir_we = wr_dir_i & ~hold & ~wipe;
  assign dat_we = wr_dat_i & ~hold & ~wipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_o <= '0;
      dat_o <= '0;
    end else if (wipe) begin
      dir_o <= '0;
      dat_o <= '0;
    end else begin
      if (dir_we) dir_o <= wdata_i;
      if (dat_we) dat_o <= wdata_i;
    end
  end

  a_r2_stby_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby_i |=> (dir_o == '0) && (dat_o == '0));

  a_r3_retain: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !hw_stby_i) |=> $stable(dir_o) && $stable(dat_o));

endmodule

// File: rtl/gport_sync.sv
module gport_sync #(
  parameter int unsigned N_PIN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] pad_in_i,
  output logic [N_PIN-1:0] sync_o
);

  logic [N_PIN-1:0] stage1;

  for (genvar i = 0; i < N_PIN; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[i] <= 1'b0;
        sync_o[i] <= 1'b0;
      end else begin
        stage1[i] <= pad_in_i[i];
        sync_o[i] <= stage1[i];
      end
    end
  end

  // Count edges since reset so the two-edge look-back starts valid.
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r11_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (sync_o == $past(pad_in_i, 2)));

endmodule

// File: rtl/gport_pinmux.sv
module gport_pinmux
  import gport_pkg::*;
#(
  parameter int unsigned N_PIN  = 5,
  parameter int unsigned MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [N_PIN-1:0]  dir_i,
  input  logic [N_PIN-1:0]  dat_i,
  input  logic [GP_NCS-1:0] cs_n_i,
  output logic [N_PIN-1:0]  pad_out_o,
  output logic [N_PIN-1:0]  pad_oe_o,
  output logic [N_PIN-1:0]  cs_act_o
);

  int unsigned mode_u;
  logic [3:0]  cs_ext;

  assign mode_u = int'(mode_i);
  assign cs_ext = {1'b1, cs_n_i};

  for (genvar i = 0; i < N_PIN; i++) begin : g_pin
    gp_route_t rt;
    assign rt          = gp_route(i, mode_u);
    assign cs_act_o[i] = rt.act & dir_i[i];
    assign pad_oe_o[i] = dir_i[i];
    assign pad_out_o[i] = !dir_i[i] ? 1'b0 :
                          rt.act     ? cs_ext[rt.idx] : dat_i[i];
  end

  a_r7_mode0_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == '0) |-> (cs_act_o == '0));

  a_r12_low_pins_plain: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act_o[1:0] == 2'b00);

  a_r8_off_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out_o & ~pad_oe_o) == '0);

  a_r4_pin4_cs0: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act_o[4] |-> (pad_out_o[4] == cs_n_i[0]));

  a_r9_cs_low_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act_o[3] && !cs_n_i[1]) |-> !pad_out_o[3]);

endmodule

// File: rtl/gport_mux.sv
module gport_mux
  import gport_pkg::*;
#(
  parameter int unsigned N_PIN  = 5,
  parameter int unsigned MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby_i,
  input  logic              man_rst_i,
  input  logic              sw_stby_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              wr_dir_i,
  input  logic              wr_dat_i,
  input  logic [N_PIN-1:0]  wdata_i,
  input  logic [2:0]        cs_n_i,
  input  logic [N_PIN-1:0]  pad_in_i,
  output logic [N_PIN-1:0]  pad_out_o,
  output logic [N_PIN-1:0]  pad_oe_o,
  output logic [N_PIN-1:0]  rd_pins_o
);

  logic [N_PIN-1:0] dir_q;
  logic [N_PIN-1:0] dat_q;
  logic [N_PIN-1:0] pad_sync;
  logic [N_PIN-1:0] cs_act;
  logic [N_PIN-1:0] gp_out;

  gport_regs #(.N_PIN(N_PIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .hw_stby_i(hw_stby_i), .man_rst_i(man_rst_i),
    .sw_stby_i(sw_stby_i), .wr_dir_i(wr_dir_i), .wr_dat_i(wr_dat_i),
    .wdata_i(wdata_i), .dir_o(dir_q), .dat_o(dat_q)
  );

  gport_sync #(.N_PIN(N_PIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in_i(pad_in_i), .sync_o(pad_sync)
  );

  gport_pinmux #(.N_PIN(N_PIN), .MODE_W(MODE_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dir_i(dir_q), .dat_i(dat_q),
    .cs_n_i(cs_n_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .cs_act_o(cs_act)
  );

  assign gp_out    = dir_q & ~cs_act;
  assign rd_pins_o = (gp_out & dat_q) | (~gp_out & pad_sync);

  a_r10_gp_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_pins_o ^ dat_q) & pad_oe_o & ~cs_act) == '0);

  a_r10_cs_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_pins_o ^ pad_sync) & cs_act) == '0);

endmodule

// File: tb/gport_mux_tb.sv
module gport_mux_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_stby_i = 1'b0, man_rst_i = 1'b0, sw_stby_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic       wr_dir_i = 1'b0, wr_dat_i = 1'b0;
  logic [4:0] wdata_i = '0;
  logic [2:0] cs_n_i = 3'b111;
  logic [4:0] pad_in_i = '0;
  logic [4:0] pad_out_o, pad_oe_o, rd_pins_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gport_mux u_dut (
    .clk(clk), .rst_n(rst_n), .hw_stby_i(hw_stby_i), .man_rst_i(man_rst_i),
    .sw_stby_i(sw_stby_i), .mode_i(mode_i), .wr_dir_i(wr_dir_i), .wr_dat_i(wr_dat_i),
    .wdata_i(wdata_i), .cs_n_i(cs_n_i), .pad_in_i(pad_in_i),
    .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .rd_pins_o(rd_pins_o)
  );

  // {mode, dir, dat, cs_n, expected pad_out, expected pad_oe}
  localparam int NV = 11;
  localparam logic [25:0] VECS [NV] = '{
    {3'd0, 5'b11111, 5'b10101, 3'b010, 5'b10101, 5'b11111},
    {3'd1, 5'b11111, 5'b10101, 3'b010, 5'b00101, 5'b11111},
    {3'd2, 5'b11111, 5'b10101, 3'b010, 5'b00101, 5'b11111},
    {3'd3, 5'b11111, 5'b10101, 3'b010, 5'b10101, 5'b11111},
    {3'd4, 5'b11111, 5'b10101, 3'b010, 5'b01001, 5'b11111},
    {3'd5, 5'b11111, 5'b10101, 3'b010, 5'b01001, 5'b11111},
    {3'd6, 5'b11111, 5'b10101, 3'b010, 5'b01001, 5'b11111},
    {3'd7, 5'b11111, 5'b10101, 3'b010, 5'b10101, 5'b11111},
    {3'd4, 5'b00011, 5'b10101, 3'b010, 5'b00001, 5'b00011},
    {3'd4, 5'b11100, 5'b00000, 3'b101, 5'b10100, 5'b11100},
    {3'd1, 5'b11100, 5'b00000, 3'b101, 5'b10000, 5'b11100}
  };

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic write_regs(input logic [4:0] d, input logic [4:0] v);
    @(negedge clk);
    wr_dir_i = 1'b1; wdata_i = d;
    @(negedge clk);
    wr_dir_i = 1'b0; wr_dat_i = 1'b1; wdata_i = v;
    @(negedge clk);
    wr_dat_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    pad_in_i = 5'b10110;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", pad_oe_o, 5'b00000);
    chk("R1 out in reset", pad_out_o, 5'b00000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 read follows pad", rd_pins_o, 5'b10110);

    // R11 synchronizer delay
    pad_in_i = 5'b01101;
    @(negedge clk);
    chk("R11 one edge old", rd_pins_o, 5'b10110);
    @(negedge clk);
    chk("R11 two edges new", rd_pins_o, 5'b01101);

    // Table walk: R4 R5 R6 R7 R8 R12
    for (int k = 0; k < NV; k++) begin
      write_regs(VECS[k][22:18], VECS[k][17:13]);
      mode_i = VECS[k][25:23];
      cs_n_i = VECS[k][12:10];
      #1;
      chk($sformatf("R4/R5/R6/R7/R8/R12 vec%0d out", k), pad_out_o, VECS[k][9:5]);
      chk($sformatf("R8 vec%0d oe", k), pad_oe_o, VECS[k][4:0]);
    end

    // R9 combinational pass-through
    write_regs(5'b11100, 5'b00000);
    mode_i = 3'd4; cs_n_i = 3'b111;
    #1 chk("R9 idle strobes", pad_out_o, 5'b11100);
    #1 cs_n_i = 3'b011;
    #1 chk("R9 same-cycle strobe", pad_out_o, 5'b11000);

    // R10 read-back
    cs_n_i = 3'b111;
    pad_in_i = 5'b01010;
    repeat (3) @(negedge clk);
    chk("R10 cs pins read pad", rd_pins_o, 5'b01010);
    write_regs(5'b11100, 5'b11111);
    mode_i = 3'd3;
    #1 chk("R10 gp pins read data", rd_pins_o, 5'b11110);

    // R3 manual reset and software standby retain
    mode_i = 3'd0;
    write_regs(5'b11111, 5'b01010);
    @(negedge clk);
    man_rst_i = 1'b1; wr_dir_i = 1'b1; wr_dat_i = 1'b1; wdata_i = 5'b00000;
    @(negedge clk);
    man_rst_i = 1'b0; wr_dir_i = 1'b0; wr_dat_i = 1'b0;
    chk("R3 manual reset oe kept", pad_oe_o, 5'b11111);
    chk("R3 manual reset data kept", pad_out_o, 5'b01010);
    sw_stby_i = 1'b1; wr_dat_i = 1'b1; wdata_i = 5'b10101;
    @(negedge clk);
    sw_stby_i = 1'b0; wr_dat_i = 1'b0;
    chk("R3 sw standby data kept", pad_out_o, 5'b01010);

    // R2 hardware standby clears, beats a same-cycle write
    hw_stby_i = 1'b1; wr_dir_i = 1'b1; wdata_i = 5'b11111;
    @(negedge clk);
    hw_stby_i = 1'b0; wr_dir_i = 1'b0;
    chk("R2 standby oe cleared", pad_oe_o, 5'b00000);
    chk("R2 standby out cleared", pad_out_o, 5'b00000);

    // R1 power-on reset mid-run
    write_regs(5'b11111, 5'b11111);
    rst_n = 1'b0;
    #1 chk("R1 mid-run reset oe", pad_oe_o, 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 registers stay clear", pad_out_o, 5'b00000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule